// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides, for each received Ethernet frame, whether it should be kept. The decision is based only on the frame's 48-bit destination address. Software programs a small table of station addresses, turns individual entries on or off, and picks a policy through a command word. The policy can accept every unicast, every multicast or every broadcast frame, each on its own. It can also compare against the table, and the result of that comparison can be inverted.

The receive path presents the destination address together with a one-cycle valid strobe. One clock later the block returns a valid flag, the accept decision, a table-hit flag and the index of the entry that matched. Registers are written and read through a word-addressed 32-bit port. Writes take effect on the clock edge. Reads are combinational from the stored values.

Top module: `mac_da_filter`

## Requirements
- R1: Register map, byte offsets with the two low address bits ignored. The policy word is at 0x00 and reads back bits 4:0 with the upper bits zero. The entry-enable word is at 0x04, bit n enabling entry n. Entry n has its upper word at 0x08+8n and its lower word at 0x0C+8n; bits 15:0 of the lower word are not stored and read as zero. Any other offset reads as zero and ignores writes.
- R2: The destination port `da` carries address byte 0 in bits 47:40 through byte 5 in bits 7:0. An entry's upper word holds bytes 0..3 (byte 0 in bits 31:24) and bits 31:16 of its lower word hold bytes 4 and 5, so an entry equals `da` when {upper word, lower word[31:16]} == `da`.
- R3: An entry can match only while its enable bit is 1 and policy bit 4 (compare-enable) is 1. A disabled entry never matches, whatever it holds. With bit 4 clear, `dec_hit` is 0.
- R4: Policy bit 3 (complement) inverts the table-match result when bit 4 is set. A frame equal to no enabled entry then gives `dec_hit`=1, and a frame equal to one gives `dec_hit`=0. Bit 3 has no effect while bit 4 is clear.
- R5: Classification and class acceptance. An all-ones address is broadcast and is accepted when policy bit 2 is 1. An address with bit 40 (bit 0 of byte 0) set that is not all ones is multicast and is accepted when bit 1 is 1. Any other address is unicast and is accepted when bit 0 is 1.
- R6: `dec_accept` is the OR of `dec_hit` and the class acceptance of R5. A frame that satisfies none of them is rejected.
- R7: The outputs are registered. `dec_valid` is 1 exactly one clock after `da_valid` was 1. In a cycle where `dec_valid` is 0, `dec_accept`, `dec_hit` and `dec_index` are all 0.
- R8: When several enabled entries equal the address, `dec_index` reports the lowest-numbered one. `dec_index` is 0 whenever `dec_hit` is 0, and also for a hit that comes from complement mode.
- R9: After reset, every register reads as zero and all outputs are 0.
- R10: When a register write and a frame arrive in the same cycle, the frame is judged against the table and policy as they stood before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RAW | Register byte offset (write and read) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| da_valid | input | 1 | Destination address valid strobe |
| da | input | 48 | Destination address, byte 0 in bits 47:40 |
| dec_valid | output | 1 | Decision valid, one clock after `da_valid` |
| dec_accept | output | 1 | Frame accepted |
| dec_hit | output | 1 | Table comparison result after complement |
| dec_index | output | log2(N_ENT) | Lowest matching entry when hit, else 0 |

## Verification
The hardest situations to reach from the ports are the ones where several rules act on the same cycle. One is an address held by more than one entry while enables change, which tests that the lowest index wins. Another is complement mode, where a hit must carry index zero. The third is a register write landing on the same edge as the frame it would change. Directed sequences set up each of these on purpose: duplicated entries with selective disabling, complement with and without compare-enable, and a write to entry 0 issued together with a frame carrying its old address. A long randomized phase follows. It draws destination addresses mostly from the entries currently programmed, so hits, priority ties and policy changes land on the same cycles, and a behavioural model checks the outputs on every clock.

// File: rtl/mac_da_filter.sv
module mac_da_filter #(
  parameter int N_ENT = 16,
  parameter int RAW = 8,
  localparam int IW = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [RAW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          da_valid,
  input  logic [47:0]   da,
  output logic          dec_valid,
  output logic          dec_accept,
  output logic          dec_hit,
  output logic [IW-1:0] dec_index
);

  localparam int P_UC  = 0;
  localparam int P_MC  = 1;
  localparam int P_BC  = 2;
  localparam int P_INV = 3;
  localparam int P_CMP = 4;

  logic [4:0]       cmd_q;
  logic [N_ENT-1:0] en_q;
  logic [31:0]      hi_q [N_ENT];
  logic [15:0]      lo_q [N_ENT];
  logic [RAW-1:0]   word;
  logic [N_ENT-1:0] match;
  logic             any_match;
  logic [IW-1:0]    first_idx;
  logic             is_bc, is_mc, is_uc;
  logic             tbl_hit, accept_d;

  assign word = reg_addr >> 2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      en_q  <= '0;
      for (int i = 0; i < N_ENT; i++) begin
        hi_q[i] <= '0;
        lo_q[i] <= '0;
      end
    end else if (reg_wr) begin
      if (word == RAW'(0)) cmd_q <= reg_wdata[4:0];
      if (word == RAW'(1)) en_q  <= reg_wdata[N_ENT-1:0];
      for (int i = 0; i < N_ENT; i++) begin
        if (word == RAW'(2 + 2*i)) hi_q[i] <= reg_wdata;
        if (word == RAW'(3 + 2*i)) lo_q[i] <= reg_wdata[31:16];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (word == RAW'(0)) reg_rdata = {27'b0, cmd_q};
    if (word == RAW'(1)) reg_rdata = 32'(en_q);
    for (int i = 0; i < N_ENT; i++) begin
      if (word == RAW'(2 + 2*i)) reg_rdata = hi_q[i];
      if (word == RAW'(3 + 2*i)) reg_rdata = {lo_q[i], 16'h0000};
    end
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign match[g] = en_q[g] && (da == {hi_q[g], lo_q[g]});
  end

  always_comb begin
    any_match = 1'b0;
    first_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (match[i]) begin
        any_match = 1'b1;
        first_idx = IW'(i);
      end
    end
  end

  assign is_bc = &da;
  assign is_mc = da[40] & ~is_bc;
  assign is_uc = ~da[40];

  assign tbl_hit  = cmd_q[P_CMP] & (any_match ^ cmd_q[P_INV]);
  assign accept_d = tbl_hit
                  | (is_uc & cmd_q[P_UC])
                  | (is_mc & cmd_q[P_MC])
                  | (is_bc & cmd_q[P_BC]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_hit    <= 1'b0;
      dec_index  <= '0;
    end else begin
      dec_valid  <= da_valid;
      dec_accept <= da_valid & accept_d;
      dec_hit    <= da_valid & tbl_hit;
      dec_index  <= (da_valid && cmd_q[P_CMP] && !cmd_q[P_INV] && any_match) ? first_idx : '0;
    end
  end

endmodule

module mac_da_filter_chk #(
  parameter int N_ENT = 16,
  parameter int RAW = 8,
  localparam int IW = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [RAW-1:0] reg_addr,
  input logic [31:0]   reg_rdata,
  input logic          da_valid,
  input logic [47:0]   da,
  input logic [4:0]    cmd_q,
  input logic          dec_valid,
  input logic          dec_accept,
  input logic          dec_hit,
  input logic [IW-1:0] dec_index
);

  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    da_valid |=> dec_valid);

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !da_valid |=> (!dec_valid && !dec_accept && !dec_hit && dec_index == '0));

  a_r6_hit_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    dec_hit |-> dec_accept);

  a_r8_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_hit |-> dec_index == '0);

  a_r3_compare_off: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && !cmd_q[4]) |=> !dec_hit);

  a_r4_inverted_index: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && cmd_q[4] && cmd_q[3]) |=> dec_index == '0);

  a_r5_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && (&da) && cmd_q[2]) |=> dec_accept);

  a_r1_low_word_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr >= RAW'(8) && reg_addr[2]) |-> reg_rdata[15:0] == 16'h0);

endmodule

bind mac_da_filter mac_da_filter_chk #(.N_ENT(N_ENT), .RAW(RAW)) u_chk (.*);

// File: tb/test_mac_da_filter.sv
`timescale 1ns/1ps
module test_mac_da_filter;
  localparam int N = 16;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic da_valid = 1'b0;
  logic [47:0] da = '0;
  logic dec_valid, dec_accept, dec_hit;
  logic [3:0] dec_index;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [4:0]  m_cmd;
  logic [15:0] m_en;
  logic [31:0] m_hi [N];
  logic [15:0] m_lo [N];
  logic        e_valid, e_acc, e_hit;
  logic [3:0]  e_idx;

  always #10 clk = ~clk;

  mac_da_filter #(.N_ENT(N), .RAW(AW)) i_mac_da_filter (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .da_valid(da_valid), .da(da),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_hit(dec_hit),
    .dec_index(dec_index));

  // reference model: judged on pre-write state, then write applied (R10)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cmd = '0; m_en = '0;
      for (int i = 0; i < N; i++) begin m_hi[i] = '0; m_lo[i] = '0; end
      e_valid = 0; e_acc = 0; e_hit = 0; e_idx = '0;
    end else begin
      bit bc, mc, uc, mt, hit;
      int idx;
      bc = (da == {48{1'b1}});
      mc = da[40] && !bc;
      uc = !da[40];
      mt = 0; idx = 0;
      for (int i = 0; i < N; i++)
        if (!mt && m_en[i] && m_hi[i] == da[47:16] && m_lo[i] == da[15:0]) begin
          mt = 1; idx = i;
        end
      hit = m_cmd[4] ? (mt != m_cmd[3]) : 0;
      e_valid = da_valid;
      e_hit   = da_valid && hit;
      e_acc   = da_valid && (hit || (uc && m_cmd[0]) || (mc && m_cmd[1]) || (bc && m_cmd[2]));
      e_idx   = (da_valid && m_cmd[4] && !m_cmd[3] && mt) ? 4'(idx) : 4'd0;
      if (reg_wr) begin
        int w;
        w = int'(reg_addr) / 4;
        if (w == 0) m_cmd = reg_wdata[4:0];
        if (w == 1) m_en = reg_wdata[15:0];
        if (w >= 2 && w < 2 + 2*N) begin
          if (w % 2 == 0) m_hi[(w-2)/2] = reg_wdata;
          else            m_lo[(w-2)/2] = reg_wdata[31:16];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (dec_valid !== e_valid || dec_accept !== e_acc || dec_hit !== e_hit || dec_index !== e_idx) begin
        errors++;
        $display("FAIL R6/R7/R8 per-cycle: got v%0b a%0b h%0b i%0d expected v%0b a%0b h%0b i%0d",
                 dec_valid, dec_accept, dec_hit, dec_index, e_valid, e_acc, e_hit, e_idx);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    reg_addr = a; #1;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s read 0x%02h: got 0x%08h expected 0x%08h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic send(input logic [47:0] x);
    @(negedge clk); da_valid = 1; da = x;
    @(negedge clk); da_valid = 0;
  endtask

  task automatic dec(input string tag, input bit acc, input bit hit, input int idx);
    checks++;
    if (dec_valid !== 1 || dec_accept !== acc || dec_hit !== hit || dec_index !== 4'(idx)) begin
      errors++;
      $display("FAIL %s: got v%0b a%0b h%0b i%0d expected v1 a%0b h%0b i%0d",
               tag, dec_valid, dec_accept, dec_hit, dec_index, acc, hit, idx);
    end
  endtask

  task automatic put(input int n, input logic [47:0] x);
    wr(8'(8 + 8*n), x[47:16]);
    wr(8'(12 + 8*n), {x[15:0], 16'hBEEF});
  endtask

  localparam logic [47:0] A0 = 48'h021122334455;
  localparam logic [47:0] A3 = 48'h0A0B0C0D0E0F;
  localparam logic [47:0] MC = 48'h01005E000001;
  localparam logic [47:0] BC = {48{1'b1}};
  localparam logic [47:0] UX = 48'h3C0000001234;

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rd("R9", 8'h00, 0); rd("R9", 8'h04, 0); rd("R9", 8'h08, 0); rd("R9", 8'h0C, 0);
    checks++;
    if (dec_valid !== 0 || dec_accept !== 0 || dec_hit !== 0 || dec_index !== 0) begin
      errors++; $display("FAIL R9 outputs: got %0b%0b%0b expected 000", dec_valid, dec_accept, dec_hit);
    end
    rst_n = 1;

    put(0, A0);
    rd("R1", 8'h0C, 32'h44550000);
    rd("R2", 8'h08, 32'h02112233);
    wr(8'h04, 32'h1); wr(8'h00, 32'h14);
    send(A0);           dec("R2 match entry0", 1, 1, 0);
    send(A0 + 48'd1);   dec("R6 unicast miss", 0, 0, 0);

    put(3, A3); put(9, A3);
    wr(8'h04, 32'h209);
    send(A3);           dec("R8 lowest of duplicates", 1, 1, 3);
    wr(8'h04, 32'h201);
    send(A3);           dec("R8 next duplicate", 1, 1, 9);
    wr(8'h04, 32'h001);
    send(A3);           dec("R3 disabled entries", 0, 0, 0);

    wr(8'h00, 32'h04);
    send(A0);           dec("R3 compare off", 0, 0, 0);
    wr(8'h00, 32'h14);
    send(BC);           dec("R5 broadcast on", 1, 0, 0);
    wr(8'h00, 32'h10);
    send(BC);           dec("R5 broadcast off", 0, 0, 0);
    wr(8'h00, 32'h14);
    send(MC);           dec("R5 multicast off", 0, 0, 0);
    wr(8'h00, 32'h16);
    send(MC);           dec("R5 multicast on", 1, 0, 0);
    wr(8'h00, 32'h11);
    send(UX);           dec("R5 all unicast", 1, 0, 0);
    send(MC);           dec("R5 multicast not unicast", 0, 0, 0);

    wr(8'h00, 32'h18);
    send(A0);           dec("R4 complement of match", 0, 0, 0);
    send(UX);           dec("R4 complement of miss", 1, 1, 0);
    wr(8'h00, 32'h08);
    send(UX);           dec("R4 complement without compare", 0, 0, 0);

    wr(8'h00, 32'h14);
    @(negedge clk);
    reg_wr = 1; reg_addr = 8'h08; reg_wdata = 32'h06778899;
    da_valid = 1; da = A0;
    @(negedge clk);
    reg_wr = 0; da_valid = 0;
    dec("R10 same-edge write", 1, 1, 0);
    send(A0);           dec("R10 old address after write", 0, 0, 0);
    send(48'h067788994455); dec("R10 new address", 1, 1, 0);

    rd("R1", 8'hFC, 0);
    wr(8'hFC, 32'hFFFFFFFF);
    rd("R1", 8'hFC, 0);
    wr(8'h00, 32'hFFFFFFFF);
    rd("R1", 8'h00, 32'h1F);
    rd("R1", 8'h04, 32'h1);

    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      reg_wr = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 3) == 0) reg_addr = 8'($urandom_range(0, 1) * 4);
      else reg_addr = 8'($urandom_range(8, 8 + 8*N + 7) & 8'hFC);
      reg_wdata = $urandom();
      if (reg_addr == 8'h04) reg_wdata = $urandom_range(0, 3) == 0 ? 32'hFFFF : $urandom();
      da_valid = $urandom_range(0, 1);
      case ($urandom_range(0, 5))
        0: da = BC;
        1: da = {$urandom(), 16'($urandom())} | 48'h010000000000;
        2: da = {$urandom(), 16'($urandom())};
        default: begin
          int k;
          k = $urandom_range(0, N - 1);
          da = {m_hi[k], m_lo[k]};
        end
      endcase
    end
    @(negedge clk);
    reg_wr = 0; da_valid = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule